// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block steps one DMA channel through a programmed run of data items. An arm pulse captures the source and destination base addresses, the item count and the per-side settings: data size, address increment and circular mode. While the channel is running it keeps a beat request raised and shows the current read address and size and the current write address and size. Each grant from the bus side completes one item. On a clean grant the remaining count drops by one and each address whose increment is enabled moves on by its data size.

Three sticky status flags report progress: half-way, complete, and bus or alignment error. Each flag is cleared by its own one-cycle clear pulse. The flags, each masked by its own enable, are combined into a single interrupt line. In circular mode the count and both addresses return to their programmed values after the last item, and the channel keeps requesting. A bus error stops the channel. An arm with a bad configuration never starts it.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset the request is low, the remaining count, both addresses and both size outputs are zero, all three flags are clear and the interrupt is low.
- R2: An arm pulse while idle, with a valid configuration, starts the channel: the request goes high on the next cycle, the remaining count shows the programmed count, and a programmed count of 0 shows 65536. While running, the remaining count is never zero.
- R3: Size codes are 0 = byte, 1 = halfword, 2 = word. Each side keeps its own size. On each clean grant, an address whose increment enable is set advances by 1, 2 or 4, and an address without it stays put.
- R4: Each clean grant lowers the remaining count by one. When it reaches zero, the complete flag is set, and in non-circular mode the request drops.
- R5: The half flag is set by the grant after which the remaining count equals the programmed total divided by two, rounded down. For a single-item run this is the same grant that completes it.
- R6: In circular mode, the grant that finishes the run reloads the remaining count to the total and both addresses to their bases, and the request stays high.
- R7: A grant with the error input high sets the error flag and stops the channel. The remaining count and the addresses keep their values.
- R8: An arm whose size code is 3, or whose base address is not a multiple of its side's size in bytes, sets the error flag and leaves the channel idle with its previous settings.
- R9: Flags stay set until their own clear input is pulsed. If a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: The interrupt is high exactly when some flag is set and that flag's enable input is high.
- R11: An arm pulse while the channel is running has no effect on the count, the addresses or the sizes.
- R12: A grant while the channel is idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start pulse; captures the configuration |
| src_base_i | input | ADDR_W | Source base address |
| dst_base_i | input | ADDR_W | Destination base address |
| count_i | input | CNT_W | Item count, 0 means 2^CNT_W |
| src_size_i | input | 2 | Source size code |
| dst_size_i | input | 2 | Destination size code |
| src_inc_i | input | 1 | Source address increment enable |
| dst_inc_i | input | 1 | Destination address increment enable |
| circ_i | input | 1 | Circular mode |
| ie_half_i | input | 1 | Interrupt enable for the half flag |
| ie_done_i | input | 1 | Interrupt enable for the complete flag |
| ie_err_i | input | 1 | Interrupt enable for the error flag |
| clr_half_i | input | 1 | Clear pulse for the half flag |
| clr_done_i | input | 1 | Clear pulse for the complete flag |
| clr_err_i | input | 1 | Clear pulse for the error flag |
| beat_gnt_i | input | 1 | One item finished on the bus |
| beat_err_i | input | 1 | Bus error for the granted item |
| beat_req_o | output | 1 | Channel is running and wants an item |
| rd_addr_o | output | ADDR_W | Current read address |
| rd_size_o | output | 2 | Read size code |
| wr_addr_o | output | ADDR_W | Current write address |
| wr_size_o | output | 2 | Write size code |
| remain_o | output | CNT_W+1 | Items left in the current run |
| half_flag_o | output | 1 | Half flag |
| done_flag_o | output | 1 | Complete flag |
| err_flag_o | output | 1 | Error flag |
| irq_o | output | 1 | Masked OR of the flags |

## Verification
A wrong item counter appears on `remain_o` at the very next check. It then sets the half or complete flag on the wrong grant, so the interrupt changes on the wrong cycle and, without circular mode, the request drops too early or too late. A corrupt address register or step amount shows on `rd_addr_o` or `wr_addr_o` one cycle after the grant, and in circular mode again on the rewind to the base. A missed error or alignment decision appears one cycle after the arm or the grant, as a request that is still high or an error flag that is still low.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic half;
        logic done;
        logic err;
    } flag_t;

    function automatic logic [2:0] size_step(xfer_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic size_ok(logic [1:0] lo, xfer_size_e s);
        case (s)
            SZ_BYTE: return 1'b1;
            SZ_HALF: return ~lo[0];
            SZ_WORD: return lo == 2'b00;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dma_seq_addr.sv
module dma_seq_addr
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        size_i,
    input  logic              inc_i,
    input  logic              step_i,
    input  logic              rewind_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        size_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] cur;
        xfer_size_e        size;
        logic              inc;
    } addr_st_t;

    addr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.base = base_i;
            st_d.cur  = base_i;
            st_d.size = xfer_size_e'(size_i);
            st_d.inc  = inc_i;
        end else if (rewind_i) begin
            st_d.cur = st_q.base;
        end else if (step_i && st_q.inc) begin
            st_d.cur = st_q.cur + ADDR_W'(size_step(st_q.size));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.cur;
    assign size_o = st_q.size;

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && st_q.inc && !load_i && !rewind_i)
        |=> (addr_o == $past(addr_o) + ADDR_W'(size_step($past(st_q.size)))));

    // R12
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i && !rewind_i) |=> $stable(addr_o));

endmodule

// File: rtl/dma_seq_count.sv
module dma_seq_count #(
    parameter int CNT_W = 16,
    localparam int TOT_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             circ_i,
    input  logic             beat_i,
    output logic [TOT_W-1:0] rem_o,
    output logic             half_o,
    output logic             last_o
);

    typedef struct packed {
        logic [TOT_W-1:0] total;
        logic [TOT_W-1:0] rem;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [TOT_W-1:0] total_in;
    logic [TOT_W-1:0] rem_m1;

    always_comb begin
        total_in = (count_i == '0) ? (TOT_W'(1) << CNT_W) : {1'b0, count_i};
        rem_m1   = st_q.rem - TOT_W'(1);
        last_o   = beat_i && (st_q.rem == TOT_W'(1));
        half_o   = beat_i && (rem_m1 == (st_q.total >> 1));
        st_d     = st_q;
        if (arm_i) begin
            st_d.total = total_in;
            st_d.rem   = total_in;
        end else if (beat_i) begin
            st_d.rem = (last_o && circ_i) ? st_q.total : rem_m1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rem_o = st_q.rem;

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i && !arm_i && !last_o) |=> (rem_o == $past(rem_o) - TOT_W'(1)));

    // R12
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_i && !arm_i) |=> $stable(rem_o));

endmodule

// File: rtl/dma_seq_flags.sv
module dma_seq_flags
    import dma_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_half_i,
    input  logic set_done_i,
    input  logic set_err_i,
    input  logic clr_half_i,
    input  logic clr_done_i,
    input  logic clr_err_i,
    input  logic ie_half_i,
    input  logic ie_done_i,
    input  logic ie_err_i,
    output logic half_o,
    output logic done_o,
    output logic err_o,
    output logic irq_o
);

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d.half = (fl_q.half && !clr_half_i) || set_half_i;
        fl_d.done = (fl_q.done && !clr_done_i) || set_done_i;
        fl_d.err  = (fl_q.err  && !clr_err_i)  || set_err_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign half_o = fl_q.half;
    assign done_o = fl_q.done;
    assign err_o  = fl_q.err;
    assign irq_o  = (fl_q.half && ie_half_i) || (fl_q.done && ie_done_i)
                 || (fl_q.err && ie_err_i);

    // R9
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_done_i |=> done_o);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_half_i && !set_half_i) |=> !half_o);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clr_err_i) |=> err_o);

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    localparam int TOT_W = CNT_W + 1,
    localparam int SIDES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [ADDR_W-1:0] src_base_i,
    input  logic [ADDR_W-1:0] dst_base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [1:0]        src_size_i,
    input  logic [1:0]        dst_size_i,
    input  logic              src_inc_i,
    input  logic              dst_inc_i,
    input  logic              circ_i,
    input  logic              ie_half_i,
    input  logic              ie_done_i,
    input  logic              ie_err_i,
    input  logic              clr_half_i,
    input  logic              clr_done_i,
    input  logic              clr_err_i,
    input  logic              beat_gnt_i,
    input  logic              beat_err_i,
    output logic              beat_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [1:0]        rd_size_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [1:0]        wr_size_o,
    output logic [TOT_W-1:0]  remain_o,
    output logic              half_flag_o,
    output logic              done_flag_o,
    output logic              err_flag_o,
    output logic              irq_o
);

    typedef struct packed {
        logic active;
        logic circ;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic accept, cfg_ok, start, bad_arm, beat_ok, beat_bad;
    logic half_hit, last_hit, rewind;

    logic [ADDR_W-1:0] side_base [SIDES];
    logic [1:0]        side_size [SIDES];
    logic              side_inc  [SIDES];
    logic [ADDR_W-1:0] side_addr [SIDES];
    logic [1:0]        side_szo  [SIDES];

    always_comb begin
        accept   = arm_i && !ctl_q.active;
        cfg_ok   = size_ok(src_base_i[1:0], xfer_size_e'(src_size_i))
                && size_ok(dst_base_i[1:0], xfer_size_e'(dst_size_i));
        start    = accept && cfg_ok;
        bad_arm  = accept && !cfg_ok;
        beat_ok  = ctl_q.active && beat_gnt_i && !beat_err_i;
        beat_bad = ctl_q.active && beat_gnt_i && beat_err_i;
        rewind   = last_hit && ctl_q.circ;

        ctl_d = ctl_q;
        if (start) begin
            ctl_d.active = 1'b1;
            ctl_d.circ   = circ_i;
        end else if (beat_bad) begin
            ctl_d.active = 1'b0;
        end else if (last_hit && !ctl_q.circ) begin
            ctl_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign side_base[0] = src_base_i;
    assign side_base[1] = dst_base_i;
    assign side_size[0] = src_size_i;
    assign side_size[1] = dst_size_i;
    assign side_inc[0]  = src_inc_i;
    assign side_inc[1]  = dst_inc_i;

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        dma_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (start),
            .base_i   (side_base[g]),
            .size_i   (side_size[g]),
            .inc_i    (side_inc[g]),
            .step_i   (beat_ok),
            .rewind_i (rewind),
            .addr_o   (side_addr[g]),
            .size_o   (side_szo[g])
        );
    end

    assign rd_addr_o = side_addr[0];
    assign rd_size_o = side_szo[0];
    assign wr_addr_o = side_addr[1];
    assign wr_size_o = side_szo[1];

    dma_seq_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (start),
        .count_i (count_i),
        .circ_i  (ctl_q.circ),
        .beat_i  (beat_ok),
        .rem_o   (remain_o),
        .half_o  (half_hit),
        .last_o  (last_hit)
    );

    dma_seq_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_half_i (half_hit),
        .set_done_i (last_hit),
        .set_err_i  (beat_bad || bad_arm),
        .clr_half_i (clr_half_i),
        .clr_done_i (clr_done_i),
        .clr_err_i  (clr_err_i),
        .ie_half_i  (ie_half_i),
        .ie_done_i  (ie_done_i),
        .ie_err_i   (ie_err_i),
        .half_o     (half_flag_o),
        .done_o     (done_flag_o),
        .err_o      (err_flag_o),
        .irq_o      (irq_o)
    );

    assign beat_req_o = ctl_q.active;

    // R2
    running_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_req_o |-> (remain_o != '0));

    // R4
    linear_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_hit && !ctl_q.circ) |=> !beat_req_o);

    // R6
    circ_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (beat_req_o && remain_o != '0));

    // R7
    bus_err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_req_o && beat_gnt_i && beat_err_i)
        |=> (!beat_req_o && err_flag_o && $stable(remain_o)));

    // R8
    bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_arm |=> (!beat_req_o && err_flag_o));

    // R11
    rearm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_req_o && arm_i && !beat_gnt_i)
        |=> ($stable(remain_o) && $stable(rd_addr_o) && $stable(wr_addr_o)));

endmodule

// File: tb/dma_xfer_seq_test.sv
`timescale 1ns/1ps
module dma_xfer_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 0, beat_gnt_i = 0, beat_err_i = 0;
    logic [31:0] src_base_i = 0, dst_base_i = 0;
    logic [15:0] count_i = 0;
    logic [1:0]  src_size_i = 0, dst_size_i = 0;
    logic        src_inc_i = 0, dst_inc_i = 0, circ_i = 0;
    logic        ie_half_i = 0, ie_done_i = 0, ie_err_i = 0;
    logic        clr_half_i = 0, clr_done_i = 0, clr_err_i = 0;
    logic        beat_req_o, half_flag_o, done_flag_o, err_flag_o, irq_o;
    logic [31:0] rd_addr_o, wr_addr_o;
    logic [1:0]  rd_size_o, wr_size_o;
    logic [16:0] remain_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bit          m_act, m_circ, m_si, m_di, m_h, m_d, m_e;
    int unsigned m_rem, m_tot;
    logic [31:0] m_src, m_dst, m_sb, m_db;
    bit [1:0]    m_ss, m_ds;

    always #2.5 clk = ~clk;

    dma_xfer_seq uut (.*);

    function automatic int unsigned nbytes(bit [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 0;
    endfunction

    function automatic bit aligned(logic [31:0] a, bit [1:0] s);
        if (s == 2'd3) return 1'b0;
        return (a % nbytes(s)) == 0;
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "req", beat_req_o, m_act);
        chk(tag, "remain", remain_o, m_rem);
        chk(tag, "rd_addr", rd_addr_o, m_src);
        chk(tag, "wr_addr", wr_addr_o, m_dst);
        chk(tag, "rd_size", rd_size_o, m_ss);
        chk(tag, "wr_size", wr_size_o, m_ds);
        chk(tag, "flags", {half_flag_o, done_flag_o, err_flag_o}, {m_h, m_d, m_e});
        chk(tag, "irq", irq_o, (m_h & ie_half_i) | (m_d & ie_done_i) | (m_e & ie_err_i));
    endtask

    // called at a falling edge; applies one cycle of stimulus and checks the result
    task automatic step(bit arm, bit gnt, bit err, bit [2:0] clr, string tag);
        bit sh = 0, sd = 0, se = 0;
        arm_i = arm; beat_gnt_i = gnt; beat_err_i = err;
        {clr_err_i, clr_done_i, clr_half_i} = clr;
        if (arm && !m_act) begin
            if (aligned(src_base_i, src_size_i) && aligned(dst_base_i, dst_size_i)) begin
                m_act = 1; m_circ = circ_i;
                m_tot = (count_i == 0) ? 65536 : count_i;
                m_rem = m_tot;
                m_sb = src_base_i; m_db = dst_base_i; m_src = m_sb; m_dst = m_db;
                m_ss = src_size_i; m_ds = dst_size_i; m_si = src_inc_i; m_di = dst_inc_i;
            end else se = 1;
        end else if (gnt && m_act) begin
            if (err) begin
                se = 1; m_act = 0;
            end else begin
                m_rem--;
                if (m_si) m_src += nbytes(m_ss);
                if (m_di) m_dst += nbytes(m_ds);
                if (m_rem == m_tot / 2) sh = 1;
                if (m_rem == 0) begin
                    sd = 1;
                    if (m_circ) begin
                        m_rem = m_tot; m_src = m_sb; m_dst = m_db;
                    end else m_act = 0;
                end
            end
        end
        m_h = (m_h & !clr[0]) | sh;
        m_d = (m_d & !clr[1]) | sd;
        m_e = (m_e & !clr[2]) | se;
        @(posedge clk);
        @(negedge clk);
        arm_i = 0; beat_gnt_i = 0; beat_err_i = 0;
        {clr_err_i, clr_done_i, clr_half_i} = 3'b000;
        check_all(tag);
    endtask

    task automatic set_cfg(logic [31:0] sb, logic [31:0] db, logic [15:0] n,
                           logic [1:0] ss, logic [1:0] ds, bit si, bit di, bit c);
        src_base_i = sb; dst_base_i = db; count_i = n;
        src_size_i = ss; dst_size_i = ds; src_inc_i = si; dst_inc_i = di; circ_i = c;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1");

        // R2 R3 R4 R5: four items, word reads, byte writes
        ie_done_i = 1;
        set_cfg(32'h1000, 32'h2003, 16'd4, 2'd2, 2'd0, 1, 1, 0);
        step(1, 0, 0, 3'b000, "R2");
        step(0, 1, 0, 3'b000, "R3");
        step(0, 1, 0, 3'b000, "R5");
        step(0, 1, 0, 3'b000, "R4");
        step(0, 1, 0, 3'b000, "R4");
        step(0, 1, 0, 3'b000, "R12");
        step(0, 0, 0, 3'b011, "R9");

        // R8 misaligned base and reserved size
        ie_err_i = 1;
        set_cfg(32'h3002, 32'h4000, 16'd5, 2'd2, 2'd1, 1, 1, 0);
        step(1, 0, 0, 3'b000, "R8");
        step(0, 0, 0, 3'b100, "R9");
        set_cfg(32'h3000, 32'h4000, 16'd5, 2'd3, 2'd1, 1, 1, 0);
        step(1, 0, 0, 3'b000, "R8");
        step(0, 0, 0, 3'b100, "R9");

        // R6 circular, fixed destination, clear of done racing its set
        set_cfg(32'h5000, 32'h6004, 16'd3, 2'd1, 2'd2, 1, 0, 1);
        step(1, 0, 0, 3'b000, "R2");
        step(0, 1, 0, 3'b000, "R6");
        step(0, 1, 0, 3'b000, "R6");
        step(0, 1, 0, 3'b010, "R9");
        step(0, 1, 0, 3'b001, "R6");
        step(0, 0, 0, 3'b000, "R10");
        step(0, 1, 1, 3'b000, "R7");
        step(0, 0, 0, 3'b111, "R9");

        // R2 count zero, R11 re-arm while running
        set_cfg(32'h8000, 32'h9000, 16'd0, 2'd0, 2'd0, 1, 1, 0);
        step(1, 0, 0, 3'b000, "R2");
        set_cfg(32'hA000, 32'hB000, 16'd2, 2'd2, 2'd2, 0, 0, 1);
        step(1, 0, 0, 3'b000, "R11");
        step(0, 1, 0, 3'b000, "R3");
        step(1, 1, 0, 3'b000, "R11");
        step(0, 1, 1, 3'b000, "R7");

        // R5 single item run
        set_cfg(32'hC000, 32'hD000, 16'd1, 2'd0, 2'd0, 1, 1, 0);
        step(0, 0, 0, 3'b111, "R9");
        step(1, 0, 0, 3'b000, "R2");
        step(0, 1, 0, 3'b000, "R5");
        ie_half_i = 1; ie_done_i = 0; ie_err_i = 0;
        step(0, 0, 0, 3'b000, "R10");

        // random phase
        for (int i = 0; i < 400; i++) begin
            bit [2:0] clr = ($urandom_range(9) == 0) ? 3'($urandom) : 3'b000;
            if ($urandom_range(15) == 0)
                {ie_half_i, ie_done_i, ie_err_i} = 3'($urandom);
            if (!m_act) begin
                logic [1:0] ss = 2'($urandom_range(2));
                logic [1:0] ds = 2'($urandom_range(2));
                logic [31:0] sb = $urandom & ~32'(nbytes(ss) - 1);
                logic [31:0] db = $urandom & ~32'(nbytes(ds) - 1);
                if ($urandom_range(7) == 0) sb = sb | 32'd1;
                set_cfg(sb, db, 16'($urandom_range(9)), ss, ds,
                        1'($urandom), 1'($urandom), 1'($urandom));
                step(1, 0, 0, clr, "R8");
            end else begin
                bit g = ($urandom_range(9) < 7);
                bit e = ($urandom_range(39) == 0);
                bit a = ($urandom_range(19) == 0);
                step(a, g, e, clr, g ? "R4" : "R11");
            end
        end

        finish_run();
    end

endmodule